// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a 16-bit position count. Both phases are brought into the clock domain through two-flop synchronisers. Each phase change is then classed as a counting edge or an ignored edge under the selected edge mode. A counting edge moves the position one step up or down, and the level of the opposite phase sets which way.

Software drives the block through a small word-wide register port. The port lets software start and stop counting, pick the edge mode, set a wrap limit, load or read the count, read the last direction, force an update event and enable two interrupt sources. The count wraps between zero and the limit. Every wrap raises a sticky update flag. Every counted edge raises a sticky trigger flag. The interrupt line combines each flag with its own enable.

Top module: `qenc_timer`

## Requirements
- R1: After reset the count reads 0, the limit (address 5) reads 0xFFFF, the status (address 3) reads 0, the control (address 0) reads 0 and irq is low.
- R2: With mode (address 1, bits 2:0) = 001 the count steps only on a phase_a change with phase_b steady. The step is up when the new phase_a differs from phase_b and down otherwise. phase_b changes do not count.
- R3: With mode = 010 the count steps only on a phase_b change with phase_a steady. The step is up when the new phase_b equals phase_a and down otherwise. phase_a changes do not count.
- R4: With mode = 011 every single-phase change counts with the direction rules of R2 and R3, so one full forward phase cycle adds 4 and one reverse cycle subtracts 4.
- R5: A change of both phases between two synchronised samples leaves the count and the flags unchanged.
- R6: With the run bit (address 0, bit 0) clear, or with mode 000, phase changes do not move the count.
- R7: An up step taken at the limit loads 0 and sets the update flag (status bit 0).
- R8: A down step taken at 0 loads the limit and sets the update flag.
- R9: The direction bit (address 0, bit 4, read-only) reads 0 after an up step and 1 after a down step.
- R10: Status flags stay set until software writes the status register. A written 0 clears the flag at that bit position, so writing 0 clears every flag at once.
- R11: Writing 1 to bit 0 of address 6 loads 0 into the count. It sets the update flag only when the overflow-only bit (address 0, bit 1) is clear.
- R12: Each counted step sets the trigger flag (status bit 1). irq is high when (update flag and enable bit 0 of address 2) or (trigger flag and enable bit 1 of address 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The phases are first walked through whole forward and reverse Gray cycles in full quadrature mode. This separates step direction from step count and drives the count both ways across the limit and across zero. The same walks are then repeated in each single-phase mode, where only half the changes may count, so a mode that picks the wrong phase shows up as a wrong total. Double-phase jumps, runs with the block stopped and runs with mode 000 check that nothing moves. Forced update events with the overflow-only bit set and with it clear show whether that bit gates the flag.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [2:0] {
    QM_OFF  = 3'b000,
    QM_A    = 3'b001,
    QM_B    = 3'b010,
    QM_QUAD = 3'b011
  } qmode_e;

  // Direction of a step caused by a phase A change: up when A now differs from B.
  function automatic logic up_on_a(input logic a_now, input logic b_now);
    return a_now ^ b_now;
  endfunction

  // Direction of a step caused by a phase B change: up when B now equals A.
  function automatic logic up_on_b(input logic a_now, input logic b_now);
    return ~(a_now ^ b_now);
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int NCH    = 2,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin,
  output logic [NCH-1:0] cur,
  output logic [NCH-1:0] prv
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], pin[c]};
        last  <= chain[STAGES-1];
      end
    end
    assign cur[c] = chain[STAGES-1];
    assign prv[c] = last;
  end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       a_cur,
  input  logic       b_cur,
  input  logic       a_prv,
  input  logic       b_prv,
  output logic       step,
  output logic       step_up,
  output logic       bad_jump
);
  logic edge_a, edge_b;

  assign edge_a   = a_cur ^ a_prv;
  assign edge_b   = b_cur ^ b_prv;
  assign bad_jump = edge_a & edge_b;

  always_comb begin
    step    = 1'b0;
    step_up = 1'b0;
    unique case (qmode_e'(mode))
      QM_A: begin
        step    = edge_a & ~edge_b;
        step_up = up_on_a(a_cur, b_cur);
      end
      QM_B: begin
        step    = edge_b & ~edge_a;
        step_up = up_on_b(a_cur, b_cur);
      end
      QM_QUAD: begin
        step    = edge_a ^ edge_b;
        step_up = edge_a ? up_on_a(a_cur, b_cur) : up_on_b(a_cur, b_cur);
      end
      default: begin
        step    = 1'b0;
        step_up = 1'b0;
      end
    endcase
  end

  a_r5_no_step_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cur != a_prv && b_cur != b_prv) |-> !step);

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic          step_up,
  input  logic [CW-1:0] limit,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] cnt,
  output logic          dir_down,
  output logic          wrap_evt,
  output logic          step_fire
);
  function automatic logic [CW-1:0] inc_wrap(input logic [CW-1:0] v, input logic [CW-1:0] lim);
    return (v >= lim) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [CW-1:0] dec_wrap(input logic [CW-1:0] v, input logic [CW-1:0] lim);
    return (v == '0) ? lim : v - 1'b1;
  endfunction

  assign step_fire = run & step & ~ld_en;
  assign wrap_evt  = step_fire & (step_up ? (cnt >= limit) : (cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else if (ld_en) begin
      cnt <= ld_val;
    end else if (step_fire) begin
      cnt      <= step_up ? inc_wrap(cnt, limit) : dec_wrap(cnt, limit);
      dir_down <= ~step_up;
    end
  end

  a_r7_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && step_up && cnt == limit) |=> (cnt == '0));

  a_r8_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !step_up && cnt == '0) |=> (cnt == $past(limit)));

  a_r9_dir_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !step_up) |=> dir_down);

endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
  import qenc_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_a,
  input  logic          phase_b,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_MODE  = AW'(1);
  localparam logic [AW-1:0] A_IEN   = AW'(2);
  localparam logic [AW-1:0] A_STAT  = AW'(3);
  localparam logic [AW-1:0] A_CNT   = AW'(4);
  localparam logic [AW-1:0] A_LIMIT = AW'(5);
  localparam logic [AW-1:0] A_EVGEN = AW'(6);

  logic          run_q, ovf_only_q;
  logic [2:0]    mode_q;
  logic          upd_ie_q, trg_ie_q;
  logic          upd_flag_q, trg_flag_q;
  logic [CW-1:0] limit_q;

  logic [1:0] ph_cur, ph_prv;
  logic       step, step_up, bad_jump;
  logic [CW-1:0] cnt;
  logic       dir_down, wrap_evt, step_fire;

  logic wr_ctrl, wr_mode, wr_ien, wr_stat, wr_cnt, wr_lim, sw_update;
  logic ld_en;
  logic [CW-1:0] ld_val;
  logic upd_set;

  assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
  assign wr_mode   = reg_wr && reg_addr == A_MODE;
  assign wr_ien    = reg_wr && reg_addr == A_IEN;
  assign wr_stat   = reg_wr && reg_addr == A_STAT;
  assign wr_cnt    = reg_wr && reg_addr == A_CNT;
  assign wr_lim    = reg_wr && reg_addr == A_LIMIT;
  assign sw_update = reg_wr && reg_addr == A_EVGEN && reg_wdata[0];

  assign ld_en  = wr_cnt | sw_update;
  assign ld_val = wr_cnt ? reg_wdata : '0;
  assign upd_set = wrap_evt | (sw_update & ~ovf_only_q);

  qenc_sync #(.NCH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin({phase_b, phase_a}),
    .cur(ph_cur), .prv(ph_prv)
  );

  qenc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .a_cur(ph_cur[0]), .b_cur(ph_cur[1]),
    .a_prv(ph_prv[0]), .b_prv(ph_prv[1]),
    .step(step), .step_up(step_up), .bad_jump(bad_jump)
  );

  qenc_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .step(step), .step_up(step_up),
    .limit(limit_q), .ld_en(ld_en), .ld_val(ld_val),
    .cnt(cnt), .dir_down(dir_down), .wrap_evt(wrap_evt), .step_fire(step_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      ovf_only_q <= 1'b0;
      mode_q     <= 3'b000;
      upd_ie_q   <= 1'b0;
      trg_ie_q   <= 1'b0;
      limit_q    <= '1;
      upd_flag_q <= 1'b0;
      trg_flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q      <= reg_wdata[0];
        ovf_only_q <= reg_wdata[1];
      end
      if (wr_mode) mode_q <= reg_wdata[2:0];
      if (wr_ien) begin
        upd_ie_q <= reg_wdata[0];
        trg_ie_q <= reg_wdata[1];
      end
      if (wr_lim) limit_q <= reg_wdata;
      upd_flag_q <= (upd_flag_q & ~(wr_stat & ~reg_wdata[0])) | upd_set;
      trg_flag_q <= (trg_flag_q & ~(wr_stat & ~reg_wdata[1])) | step_fire;
    end
  end

  assign irq = (upd_flag_q & upd_ie_q) | (trg_flag_q & trg_ie_q);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:  begin
        reg_rdata[0] = run_q;
        reg_rdata[1] = ovf_only_q;
        reg_rdata[4] = dir_down;
      end
      A_MODE:  reg_rdata[2:0] = mode_q;
      A_IEN:   begin
        reg_rdata[0] = upd_ie_q;
        reg_rdata[1] = trg_ie_q;
      end
      A_STAT:  begin
        reg_rdata[0] = upd_flag_q;
        reg_rdata[1] = trg_flag_q;
      end
      A_CNT:   reg_rdata = cnt;
      A_LIMIT: reg_rdata = limit_q;
      default: reg_rdata = '0;
    endcase
  end

  a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ld_en) |=> $stable(cnt));

  a_r5_jump_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_jump && !trg_flag_q && !wr_stat) |=> !trg_flag_q);

  a_r10_update_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_flag_q && !wr_stat) |=> upd_flag_q);

  a_r11_ovf_only_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_only_q && sw_update && !upd_flag_q && !wrap_evt) |=> !upd_flag_q);

endmodule

// File: tb/qenc_timer_tb.sv
module qenc_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0;
  logic wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int m_cnt = 0, m_lim = 65535, m_mode = 0;
  bit m_en = 0, m_ovf_only = 0, m_uif = 0, m_tif = 0, m_dir = 0, m_uie = 0, m_tie = 0;

  always #5 clk = ~clk;

  qenc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wreg(input int a, input int d);
    @(negedge clk);
    wr = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input int a, output int d);
    @(negedge clk);
    addr = 3'(a);
    #1 d = int'(rdata);
  endtask

  // Gray position of the phase pair in forward order 00,10,11,01 (A,B)
  function automatic int gpos(input bit a, input bit b);
    if (!a && !b) return 0;
    if (a && !b)  return 1;
    if (a && b)   return 2;
    return 3;
  endfunction

  task automatic compare_all(input string req);
    int v;
    rreg(4, v); chk({req, " count"}, v, m_cnt);
    rreg(3, v); chk({req, " status"}, v, {m_tif, m_uif});
    rreg(0, v); chk({req, " dirbit"}, (v >> 4) & 1, m_dir);
    chk({req, " irq"}, int'(irq), int'((m_uif && m_uie) || (m_tif && m_tie)));
  endtask

  task automatic move(input bit na, input bit nb, input string req);
    int d;
    bit ca, cb, counts;
    d = (gpos(na, nb) - gpos(pa, pb) + 4) % 4;
    ca = (na != pa);
    cb = (nb != pb);
    counts = m_en && ((m_mode == 3 && (ca != cb)) ||
                      (m_mode == 1 && ca && !cb) ||
                      (m_mode == 2 && cb && !ca));
    if (counts) begin
      m_tif = 1;
      if (d == 1) begin
        m_dir = 0;
        if (m_cnt == m_lim) begin m_cnt = 0; m_uif = 1; end
        else m_cnt = m_cnt + 1;
      end else begin
        m_dir = 1;
        if (m_cnt == 0) begin m_cnt = m_lim; m_uif = 1; end
        else m_cnt = m_cnt - 1;
      end
    end
    @(negedge clk);
    pa = na; pb = nb;
    repeat (5) @(negedge clk);
    compare_all(req);
  endtask

  task automatic fwd(input string req);
    int p;
    p = (gpos(pa, pb) + 1) % 4;
    move(p == 1 || p == 2, p == 2 || p == 3, req);
  endtask

  task automatic rev(input string req);
    int p;
    p = (gpos(pa, pb) + 3) % 4;
    move(p == 1 || p == 2, p == 2 || p == 3, req);
  endtask

  task automatic sw_event(input string req);
    wreg(6, 1);
    m_cnt = 0;
    if (!m_ovf_only) m_uif = 1;
    compare_all(req);
  endtask

  task automatic clear_stat();
    wreg(3, 0);
    m_uif = 0; m_tif = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rreg(4, v); chk("R1 count", v, 0);
    rreg(5, v); chk("R1 limit", v, 16'hFFFF);
    rreg(3, v); chk("R1 status", v, 0);
    rreg(0, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", int'(irq), 0);

    wreg(5, 9); m_lim = 9;
    wreg(1, 3); m_mode = 3;
    wreg(0, 1); m_en = 1;

    // R4 full quadrature forward / reverse, R9 direction bit
    for (int i = 0; i < 4; i++) fwd("R4 R9 fwd");
    chk("R4 full cycle up", m_cnt, 4);
    for (int i = 0; i < 4; i++) rev("R4 R9 rev");
    // R8 down wrap from zero
    rev("R8 wrap down");
    chk("R8 at limit", m_cnt, 9);
    // R10 sticky flag then clear
    rev("R10 sticky");
    clear_stat();
    compare_all("R10 cleared");
    // R7 up wrap at limit
    fwd("R7 step"); fwd("R7 wrap up");
    // R5 double-phase jump
    clear_stat();
    move(!pa, !pb, "R5 jump");
    move(!pa, !pb, "R5 jump back");

    // R2 phase A mode
    wreg(1, 1); m_mode = 1;
    for (int i = 0; i < 4; i++) fwd("R2 mode A fwd");
    for (int i = 0; i < 2; i++) rev("R2 mode A rev");
    // R3 phase B mode
    wreg(1, 2); m_mode = 2;
    for (int i = 0; i < 4; i++) fwd("R3 mode B fwd");
    for (int i = 0; i < 2; i++) rev("R3 mode B rev");

    // R6 stopped, and mode 000
    wreg(1, 3); m_mode = 3;
    wreg(0, 0); m_en = 0;
    fwd("R6 stopped"); fwd("R6 stopped");
    wreg(0, 1); m_en = 1;
    wreg(1, 0); m_mode = 0;
    fwd("R6 mode off"); rev("R6 mode off");
    wreg(1, 3); m_mode = 3;

    // R11 software update event with and without overflow-only bit
    clear_stat();
    wreg(4, 7); m_cnt = 7;
    wreg(0, 3); m_en = 1; m_ovf_only = 1;
    sw_event("R11 gated");
    wreg(0, 1); m_ovf_only = 0;
    wreg(4, 5); m_cnt = 5;
    sw_event("R11 ungated");

    // R12 interrupt combination
    clear_stat();
    wreg(2, 1); m_uie = 1;
    compare_all("R12 no flag");
    sw_event("R12 update irq");
    clear_stat();
    compare_all("R12 cleared");
    wreg(2, 2); m_uie = 0; m_tie = 1;
    fwd("R12 trigger irq");
    chk("R12 irq high", int'(irq), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule